// File: doc/BRIEF.md
# Split-Mode Auto-Reload Timer

A 16-bit up-counting timer for a microcontroller-style peripheral. The count is held as two bytes. It runs either as one 16-bit counter or as two independent 8-bit counters. When a counter rolls over, it reloads from its own reload register instead of wrapping to zero. Each rollover sets a sticky overflow flag. A single interrupt request is formed from the flags, a low-byte interrupt enable and a global interrupt enable.

Each half of the timer takes a single-cycle count enable from one of three tick sources:

- every system clock cycle;
- one cycle in twelve;
- one tick per eight rising edges of a free-running external clock. The external clock is first brought into the system clock domain through a two-flop synchronizer.

No derived clocks exist: all state runs on `clk_i`. Software reaches the counter bytes, the reload bytes, the control register and the clock-select register through a simple write port and a combinational read port.

Top module: `srt_timer`

## Requirements
- R1: After reset, all six registers read 0, both flags are 0 and `irq_o` is 0.
- R2: Register map: address 0 is the counter low byte, 1 the counter high byte, 2 the reload low byte, 3 the reload high byte, 4 the control register, 5 the clock-select register. Addresses 6 and 7 read 0.
- R3: Control register layout: bit 7 is the high flag, bit 6 the low flag, bit 5 the low-byte interrupt enable, bit 3 the mode (0 = 16-bit, 1 = split), bit 2 run, bit 0 the external select. Clock-select register layout: bit 0 is the low-half select, bit 1 the high-half select, bit 2 the global interrupt enable. All other bits read 0.
- R4: In 16-bit mode, while run is 1, the 16-bit count advances once per low-half tick. Stepping from 0xFFFF loads the 16-bit reload value and sets both flags. While run is 0, the count holds.
- R5: In 16-bit mode, every step of the low byte from 0xFF sets the low flag.
- R6: In split mode, the low byte advances on every low-half tick whatever the run bit holds. Stepping from 0xFF loads the reload low byte and sets the low flag.
- R7: In split mode, the high byte advances on high-half ticks only while run is 1. Stepping from 0xFF loads the reload high byte and sets the high flag. While run is 0, the high byte holds.
- R8: Tick selection per half. A select bit of 1 ticks every cycle. A select bit of 0 uses the external select bit: 0 gives one tick per 12 cycles, 1 gives one tick per 8 synchronized rising edges of `ext_clk_i`. In 16-bit mode, the low-half select applies.
- R9: `irq_o` = global enable AND (high flag OR (low flag AND low-byte enable)).
- R10: Flags stay set until written 0 through the control register. A hardware set in the same cycle as a clearing write leaves the flag set.
- R11: A write to a counter byte replaces that byte's next value, overriding any count step in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ext_clk_i | input | 1 | Free-running external clock, asynchronous |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Write address |
| wr_data_i | input | 8 | Write data |
| rd_addr_i | input | 3 | Read address |
| rd_data_o | output | 8 | Read data, combinational from `rd_addr_i` |
| flag_hi_o | output | 1 | High overflow flag |
| flag_lo_o | output | 1 | Low overflow flag |
| irq_o | output | 1 | Interrupt request |

## Verification
Two pairs of events can land in the same cycle:

- A software write to a counter byte against a count step of that byte, including a reload step.
- A clearing write to the control register against a hardware flag set.

The bench provokes both by running every half from the every-cycle tick while issuing random writes to the counter and control addresses, and by placing counts at 0xFF or 0xFFFF just before such writes. A behavioural model, updated on each rising edge, decides the winner per R10 and R11. The read data, flags and interrupt are compared with it on every falling edge.

// File: rtl/srt_pkg.sv
package srt_pkg;
  localparam int unsigned ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_CNT_L  = 3'd0,
    A_CNT_H  = 3'd1,
    A_RLD_L  = 3'd2,
    A_RLD_H  = 3'd3,
    A_CTRL   = 3'd4,
    A_CKSEL  = 3'd5
  } reg_addr_e;

  localparam int unsigned C_FLAG_HI = 7;
  localparam int unsigned C_FLAG_LO = 6;
  localparam int unsigned C_LO_IE   = 5;
  localparam int unsigned C_SPLIT   = 3;
  localparam int unsigned C_RUN     = 2;
  localparam int unsigned C_XSEL    = 0;

  localparam int unsigned K_SEL_L   = 0;
  localparam int unsigned K_SEL_H   = 1;
  localparam int unsigned K_GIE     = 2;
endpackage

// File: rtl/srt_tick_gen.sv
module srt_tick_gen #(
  parameter int unsigned DIV_INT = 12,
  parameter int unsigned DIV_EXT = 8,
  parameter int unsigned SYNC_N  = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ext_clk_i,
  output logic tick_int_o,
  output logic tick_ext_o
);
  localparam int unsigned IW = (DIV_INT > 1) ? $clog2(DIV_INT) : 1;
  localparam int unsigned EW = (DIV_EXT > 1) ? $clog2(DIV_EXT) : 1;

  logic [IW-1:0]     int_cnt_q;
  logic [EW-1:0]     ext_cnt_q;
  logic [SYNC_N-1:0] sync_q;
  logic              prev_q;
  logic              ext_rise;

  assign tick_int_o = (int_cnt_q == IW'(DIV_INT - 1));
  assign ext_rise   = sync_q[SYNC_N-1] & ~prev_q;
  assign tick_ext_o = ext_rise && (ext_cnt_q == EW'(DIV_EXT - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      int_cnt_q <= '0;
      ext_cnt_q <= '0;
      sync_q    <= '0;
      prev_q    <= 1'b0;
    end else begin
      int_cnt_q <= tick_int_o ? '0 : int_cnt_q + 1'b1;
      sync_q    <= {sync_q[SYNC_N-2:0], ext_clk_i};
      prev_q    <= sync_q[SYNC_N-1];
      if (ext_rise) ext_cnt_q <= tick_ext_o ? '0 : ext_cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/srt_byte_cnt.sv
module srt_byte_cnt #(
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          inc_i,
  input  logic          reload_i,
  input  logic [DW-1:0] rld_i,
  input  logic          wr_i,
  input  logic [DW-1:0] wr_data_i,
  output logic [DW-1:0] cnt_o,
  output logic          max_o
);
  assign max_o = &cnt_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_o <= '0;
    else if (wr_i)    cnt_o <= wr_data_i;  // software wins over counting
    else if (inc_i) begin
      if (max_o)      cnt_o <= reload_i ? rld_i : '0;
      else            cnt_o <= cnt_o + 1'b1;
    end
  end
endmodule

// File: rtl/srt_timer.sv
module srt_timer
  import srt_pkg::*;
#(
  parameter int unsigned DW      = 8,
  parameter int unsigned DIV_INT = 12,
  parameter int unsigned DIV_EXT = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ext_clk_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DW-1:0]     wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DW-1:0]     rd_data_o,
  output logic              flag_hi_o,
  output logic              flag_lo_o,
  output logic              irq_o
);
  localparam int unsigned NH = 2;

  logic split_q, run_q, lo_ie_q, xsel_q, gie_q;
  logic [NH-1:0] sel_q;
  logic [NH-1:0][DW-1:0] rld_q;
  logic [NH-1:0][DW-1:0] cnt;
  logic [NH-1:0] tick, inc, reload, wr_cnt, at_max;
  logic tick_int, tick_ext;
  logic set_hi, set_lo, wr_ctrl, wr_cksel;
  logic [7:0] ctrl_rd, cksel_rd;

  srt_tick_gen #(.DIV_INT(DIV_INT), .DIV_EXT(DIV_EXT), .SYNC_N(2)) u_tick (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ext_clk_i  (ext_clk_i),
    .tick_int_o (tick_int),
    .tick_ext_o (tick_ext)
  );

  // half 0 is the low byte (address 0), half 1 the high byte (address 1)
  for (genvar h = 0; h < NH; h++) begin : g_half
    assign tick[h]   = sel_q[h] ? 1'b1 : (xsel_q ? tick_ext : tick_int);
    assign wr_cnt[h] = wr_en_i && (wr_addr_i == ADDR_W'(h));
    srt_byte_cnt #(.DW(DW)) u_cnt (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .inc_i     (inc[h]),
      .reload_i  (reload[h]),
      .rld_i     (rld_q[h]),
      .wr_i      (wr_cnt[h]),
      .wr_data_i (wr_data_i),
      .cnt_o     (cnt[h]),
      .max_o     (at_max[h])
    );
  end

  always_comb begin
    if (split_q) begin
      inc[0]    = tick[0];
      inc[1]    = run_q & tick[1];
      reload[0] = 1'b1;
    end else begin
      inc[0]    = run_q & tick[0];
      inc[1]    = run_q & tick[0] & at_max[0];
      reload[0] = at_max[1];  // low byte reloads only on full 16-bit wrap
    end
    reload[1] = 1'b1;
  end

  assign set_lo   = inc[0] & at_max[0];
  assign set_hi   = inc[1] & at_max[1];
  assign wr_ctrl  = wr_en_i && (wr_addr_i == A_CTRL);
  assign wr_cksel = wr_en_i && (wr_addr_i == A_CKSEL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rld_q     <= '0;
      split_q   <= 1'b0;
      run_q     <= 1'b0;
      lo_ie_q   <= 1'b0;
      xsel_q    <= 1'b0;
      gie_q     <= 1'b0;
      sel_q     <= '0;
      flag_hi_o <= 1'b0;
      flag_lo_o <= 1'b0;
    end else begin
      if (wr_en_i && wr_addr_i == A_RLD_L) rld_q[0] <= wr_data_i;
      if (wr_en_i && wr_addr_i == A_RLD_H) rld_q[1] <= wr_data_i;
      if (wr_ctrl) begin
        split_q <= wr_data_i[C_SPLIT];
        run_q   <= wr_data_i[C_RUN];
        lo_ie_q <= wr_data_i[C_LO_IE];
        xsel_q  <= wr_data_i[C_XSEL];
      end
      if (wr_cksel) begin
        sel_q[0] <= wr_data_i[K_SEL_L];
        sel_q[1] <= wr_data_i[K_SEL_H];
        gie_q    <= wr_data_i[K_GIE];
      end
      // hardware set beats a clearing write
      flag_hi_o <= (wr_ctrl ? wr_data_i[C_FLAG_HI] : flag_hi_o) | set_hi;
      flag_lo_o <= (wr_ctrl ? wr_data_i[C_FLAG_LO] : flag_lo_o) | set_lo;
    end
  end

  assign irq_o = gie_q & (flag_hi_o | (flag_lo_o & lo_ie_q));

  always_comb begin
    ctrl_rd = '0;
    ctrl_rd[C_FLAG_HI] = flag_hi_o;
    ctrl_rd[C_FLAG_LO] = flag_lo_o;
    ctrl_rd[C_LO_IE]   = lo_ie_q;
    ctrl_rd[C_SPLIT]   = split_q;
    ctrl_rd[C_RUN]     = run_q;
    ctrl_rd[C_XSEL]    = xsel_q;
    cksel_rd = '0;
    cksel_rd[K_SEL_L]  = sel_q[0];
    cksel_rd[K_SEL_H]  = sel_q[1];
    cksel_rd[K_GIE]    = gie_q;
    case (rd_addr_i)
      A_CNT_L: rd_data_o = cnt[0];
      A_CNT_H: rd_data_o = cnt[1];
      A_RLD_L: rd_data_o = rld_q[0];
      A_RLD_H: rd_data_o = rld_q[1];
      A_CTRL:  rd_data_o = DW'(ctrl_rd);
      A_CKSEL: rd_data_o = DW'(cksel_rd);
      default: rd_data_o = '0;
    endcase
  end
endmodule

// File: rtl/srt_timer_chk.sv
module srt_timer_chk #(
  parameter int unsigned DW = 8
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            wr_en_i,
  input logic [2:0]      wr_addr_i,
  input logic [DW-1:0]   wr_data_i,
  input logic            split_i,
  input logic            run_i,
  input logic            tick_l_i,
  input logic [2*DW-1:0] cnt_i,
  input logic [2*DW-1:0] rld_i,
  input logic            flag_hi_i,
  input logic            flag_lo_i,
  input logic            irq_i
);
  logic wr_lo, wr_hi, wr_ctl;
  assign wr_lo  = wr_en_i && wr_addr_i == 3'd0;
  assign wr_hi  = wr_en_i && wr_addr_i == 3'd1;
  assign wr_ctl = wr_en_i && wr_addr_i == 3'd4;

  AST_WRAP_16: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!split_i && run_i && tick_l_i && (&cnt_i) && !wr_lo && !wr_hi)
    |=> (cnt_i == $past(rld_i)) && flag_hi_i) else $error("wrap16"); // R4

  AST_SPLIT_LO_RELOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (split_i && tick_l_i && (&cnt_i[DW-1:0]) && !wr_lo)
    |=> (cnt_i[DW-1:0] == $past(rld_i[DW-1:0])) && flag_lo_i) else $error("split lo"); // R6

  AST_SPLIT_LO_FREE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (split_i && !run_i && tick_l_i && !(&cnt_i[DW-1:0]) && !wr_lo)
    |=> cnt_i[DW-1:0] == $past(cnt_i[DW-1:0]) + 1'b1) else $error("lo free"); // R6

  AST_SPLIT_HI_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (split_i && !run_i && !wr_hi) |=> $stable(cnt_i[2*DW-1:DW])) else $error("hi hold"); // R7

  AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_hi_i && !wr_ctl) |=> flag_hi_i) else $error("sticky"); // R10

  AST_WRITE_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_lo |=> cnt_i[DW-1:0] == $past(wr_data_i)) else $error("wr prio"); // R11

  AST_IRQ_SOURCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_i |-> (flag_hi_i || flag_lo_i)) else $error("irq src"); // R9
endmodule

bind srt_timer srt_timer_chk #(.DW(DW)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_en_i   (wr_en_i),
  .wr_addr_i (wr_addr_i),
  .wr_data_i (wr_data_i),
  .split_i   (split_q),
  .run_i     (run_q),
  .tick_l_i  (tick[0]),
  .cnt_i     ({cnt[1], cnt[0]}),
  .rld_i     ({rld_q[1], rld_q[0]}),
  .flag_hi_i (flag_hi_o),
  .flag_lo_i (flag_lo_o),
  .irq_i     (irq_o)
);

// File: tb/srt_timer_test.sv
`timescale 1ns/1ps
module srt_timer_test;
  logic clk = 1'b0, rst_n = 1'b0, ext_clk = 1'b0;
  logic wr_en = 1'b0;
  logic [2:0] wr_addr = '0, rd_addr = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic flag_hi, flag_lo, irq;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  srt_timer uut (
    .clk_i(clk), .rst_ni(rst_n), .ext_clk_i(ext_clk), .wr_en_i(wr_en),
    .wr_addr_i(wr_addr), .wr_data_i(wr_data), .rd_addr_i(rd_addr),
    .rd_data_o(rd_data), .flag_hi_o(flag_hi), .flag_lo_o(flag_lo), .irq_o(irq)
  );

  // reference model
  int m_cl, m_ch, m_rl, m_rh, m_e8, m_d12;
  bit m_fh, m_fl, m_lie, m_split, m_run, m_xsel, m_sell, m_selh, m_gie, m_s1, m_s2, m_s3;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cl = 0; m_ch = 0; m_rl = 0; m_rh = 0; m_e8 = 0; m_d12 = 0;
      m_fh = 0; m_fl = 0; m_lie = 0; m_split = 0; m_run = 0; m_xsel = 0;
      m_sell = 0; m_selh = 0; m_gie = 0; m_s1 = 0; m_s2 = 0; m_s3 = 0;
    end else begin
      bit rise, t8, t12, tl, th, sh, sl;
      int nl, nh;
      rise = m_s2 && !m_s3;
      t8 = rise && m_e8 == 7;
      t12 = m_d12 == 11;
      tl = m_sell ? 1'b1 : (m_xsel ? t8 : t12);
      th = m_selh ? 1'b1 : (m_xsel ? t8 : t12);
      sh = 0; sl = 0; nl = m_cl; nh = m_ch;
      if (!m_split) begin
        if (m_run && tl) begin
          if (m_cl == 255) begin
            sl = 1;
            if (m_ch == 255) begin sh = 1; nl = m_rl; nh = m_rh; end
            else begin nl = 0; nh = m_ch + 1; end
          end else nl = m_cl + 1;
        end
      end else begin
        if (tl) begin
          if (m_cl == 255) begin nl = m_rl; sl = 1; end else nl = m_cl + 1;
        end
        if (m_run && th) begin
          if (m_ch == 255) begin nh = m_rh; sh = 1; end else nh = m_ch + 1;
        end
      end
      if (wr_en) begin
        case (wr_addr)
          3'd0: nl = wr_data;
          3'd1: nh = wr_data;
          3'd2: m_rl = wr_data;
          3'd3: m_rh = wr_data;
          3'd4: begin
            m_fh = wr_data[7]; m_fl = wr_data[6]; m_lie = wr_data[5];
            m_split = wr_data[3]; m_run = wr_data[2]; m_xsel = wr_data[0];
          end
          3'd5: begin m_sell = wr_data[0]; m_selh = wr_data[1]; m_gie = wr_data[2]; end
          default: ;
        endcase
      end
      m_fh = m_fh | sh;
      m_fl = m_fl | sl;
      m_cl = nl; m_ch = nh;
      if (rise) m_e8 = (m_e8 + 1) % 8;
      m_d12 = (m_d12 == 11) ? 0 : m_d12 + 1;
      m_s3 = m_s2; m_s2 = m_s1; m_s1 = ext_clk;
    end
  end

  function automatic int m_read(int a);
    case (a)
      0: return m_cl;
      1: return m_ch;
      2: return m_rl;
      3: return m_rh;
      4: return {m_fh, m_fl, m_lie, 1'b0, m_split, m_run, 1'b0, m_xsel};
      5: return {5'b0, m_gie, m_selh, m_sell};
      default: return 0;
    endcase
  endfunction

  function automatic string tag_of(int a);
    case (a)
      0, 1: return "R4/R5/R6/R7/R8/R11 count";
      2, 3: return "R2 reload";
      4: return "R3/R10 ctrl";
      5: return "R3 cksel";
      default: return "R2 unmapped";
    endcase
  endfunction

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (!done) begin
    check(tag_of(int'(rd_addr)), int'(rd_data), m_read(int'(rd_addr)));
    check("R10 flag_hi", int'(flag_hi), int'(m_fh));
    check("R5/R10 flag_lo", int'(flag_lo), int'(m_fl));
    check("R9 irq", int'(irq), int'(m_gie && (m_fh || (m_fl && m_lie))));
  end

  // external clock: period of 7 system cycles, driven off the falling edge
  initial begin
    int k = 0;
    forever begin
      @(negedge clk); #1;
      k++;
      if ((ext_clk && k >= 4) || (!ext_clk && k >= 3)) begin ext_clk = ~ext_clk; k = 0; end
    end
  end

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); #1;
      wr_en = 0;
      rd_addr = 3'($urandom % 8);
    end
  endtask

  task automatic wr(int a, int d);
    @(negedge clk); #1;
    wr_en = 1; wr_addr = 3'(a); wr_data = 8'(d);
    rd_addr = 3'($urandom % 8);
    @(negedge clk); #1;
    wr_en = 0;
  endtask

  task automatic rd_chk(string tag, int a, int exp);
    @(negedge clk); #1;
    wr_en = 0; rd_addr = 3'(a);
    #1 check(tag, int'(rd_data), exp);
  endtask

  initial begin
    #40 rst_n = 1;
    for (int a = 0; a < 8; a++) rd_chk("R1 reset", a, 0);
    check("R1 irq", int'(irq), 0);

    // 16-bit, every-cycle tick, wrap into reload
    wr(5, 8'h05); wr(2, 8'h34); wr(3, 8'h12); wr(0, 8'hFC); wr(1, 8'hFF);
    wr(4, 8'h24);
    idle(300);
    wr(4, 8'h20);                       // clear flags, keep enable
    // 16-bit held with run=0
    wr(0, 8'h77); wr(1, 8'h66);
    idle(20);
    rd_chk("R4 hold lo", 0, 8'h77);
    rd_chk("R4 hold hi", 1, 8'h66);

    // 16-bit on divide-by-12, then external/8
    wr(5, 8'h04); wr(0, 8'hF0); wr(1, 8'hFF); wr(2, 8'hF8); wr(3, 8'hFF); wr(4, 8'h24);
    idle(600);
    wr(4, 8'h25);
    idle(1500);

    // split: low from every cycle, high from external/8, run off then on
    wr(4, 8'h00); wr(0, 8'h00); wr(1, 8'h55);
    wr(2, 8'hF0); wr(3, 8'hFC); wr(5, 8'h05);
    wr(4, 8'h09);
    idle(50);
    rd_chk("R7 hi held run=0", 1, 8'h55);
    wr(4, 8'h0D);
    idle(1500);
    wr(5, 8'h07);
    idle(200);

    // collisions: random writes while both halves tick every cycle
    for (int i = 0; i < 4000; i++) begin
      int a = $urandom % 6;
      int d = $urandom % 256;
      if (a == 4) d = d & 8'hED;
      if (a == 5) d = d | 3;
      if ($urandom % 3 == 0) d = 8'hFF;
      if ($urandom % 2) wr(a, d); else idle(1 + $urandom % 3);
    end
    for (int i = 0; i < 400; i++) begin
      wr(0, 8'hFF); wr(4, 8'h0C | ($urandom % 2 ? 8'h20 : 8'h00));
    end
    idle(20);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule